// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds a sticky record of why the device last reset or left a low-power mode. Each reset source reports a one-cycle event pulse. These sources are power-on, brown-out, the external reset pin, the software reset command, configuration mismatch, watchdog time-out and interrupt wake. The block marks the matching cause flags. The power mode at the time of the event (run, idle or sleep) decides whether the idle or sleep flag is also marked. Flags that an event does not name keep their value.

On every event the block also produces the program counter that execution resumes from. A true reset gives the reset vector. A watchdog wake gives the interrupted PC plus two. An interrupt wake gives either PC plus two or the interrupt vector, chosen by comparing the interrupt priority with the CPU priority.

Software reads the flags and clears selected bits through a masked write port. A write clears a bit when its mask bit is 1 and its data bit is 0.

Top module: `rst_cause_reg`

## Requirements
- R1: A power-on event (or the asynchronous reset `rst_ni`) leaves the flags at 0x03: power-on (bit 0) and brown-out (bit 1) set, all others clear. After a power-on event, `pc_o` is the reset vector (0) and `pc_load_o` pulses. `pc_load_o` is 0 while in `rst_ni` reset.
- R2: A brown-out event sets bit 1 only and loads the reset vector.
- R3: An external pin event sets bit 2. It also sets bit 6 (idle) when `mode_i`=01, or bit 5 (sleep) when `mode_i`=10. It loads the reset vector. `mode_i`=00 or 11 means run.
- R4: A software reset event sets bit 3 only and loads the reset vector.
- R5: A configuration mismatch event sets bit 7 only and loads the reset vector.
- R6: A watchdog event sets bit 4. In run mode it loads the reset vector. In idle it also sets bit 6, and in sleep it also sets bit 5; in both of these cases it loads `cur_pc_i`+2 (modulo 2^24).
- R7: An interrupt wake in idle sets bit 6, and in sleep sets bit 5. In run mode it has no effect on the flags and does not pulse `pc_load_o`.
- R8: On an interrupt wake, `pc_o` is `cur_pc_i`+2 when `irq_prio_i` <= `cpu_prio_i`, and `vec_addr_i` otherwise.
- R9: Events in the same cycle resolve by priority. The order is power-on, brown-out, external pin, configuration mismatch, watchdog, software, interrupt wake. Only the winner acts.
- R10: A write with `wr_en_i` clears each flag whose `wr_mask_i` bit is 1 and whose `wr_data_i` bit is 0. It never sets a flag.
- R11: A write in the same cycle as any acting event is dropped; the event's update applies.
- R12: `pc_load_o` is high for exactly the cycle after an acting event. `pc_o` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on event pulse |
| bor_i | input | 1 | Brown-out event pulse |
| ext_i | input | 1 | External reset pin event pulse |
| swr_i | input | 1 | Software reset command pulse |
| cm_i | input | 1 | Configuration mismatch event pulse |
| wdt_i | input | 1 | Watchdog time-out pulse |
| irq_wake_i | input | 1 | Interrupt wake pulse |
| mode_i | input | 2 | Power mode: 00 run, 01 idle, 10 sleep |
| irq_prio_i | input | 3 | Priority of the waking interrupt |
| cpu_prio_i | input | 3 | Current CPU priority level |
| cur_pc_i | input | 24 | PC of the interrupted instruction |
| vec_addr_i | input | 24 | Interrupt vector address |
| wr_en_i | input | 1 | Flag write strobe |
| wr_data_i | input | 8 | Write data (0 clears) |
| wr_mask_i | input | 8 | Write bit select |
| flags_o | output | 8 | Cause flags |
| pc_load_o | output | 1 | Resume PC valid pulse |
| pc_o | output | 24 | Resume PC |

## Verification
Each event is applied on its own in run, idle and sleep mode, so that the mode-dependent extra flag and the choice between reset vector and PC+2 are both seen. Interrupt wakes use equal, lower and higher interrupt priority, which separates PC+2 from the vector and exposes an off-by-one in the compare. A watchdog wake at PC 0xFFFFFF checks the wrap. Stacked events show that only the highest-priority one acts. Masked writes with mixed data bits separate clearing from setting, and a write that collides with an event shows that the event wins.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned FLAG_N = 8;
  // flag bit positions
  localparam int unsigned F_POR = 0;
  localparam int unsigned F_BOR = 1;
  localparam int unsigned F_EXT = 2;
  localparam int unsigned F_SWR = 3;
  localparam int unsigned F_WDT = 4;
  localparam int unsigned F_SLP = 5;
  localparam int unsigned F_IDL = 6;
  localparam int unsigned F_CM  = 7;

  localparam logic [FLAG_N-1:0] POR_VAL = FLAG_N'(2'b11);

  localparam logic [1:0] MODE_IDLE  = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;

  // order is priority, highest first
  localparam int unsigned EV_N = 7;
  typedef enum logic [2:0] {
    EV_POR  = 3'd0,
    EV_BOR  = 3'd1,
    EV_EXT  = 3'd2,
    EV_CM   = 3'd3,
    EV_WDT  = 3'd4,
    EV_SWR  = 3'd5,
    EV_IRQ  = 3'd6,
    EV_NONE = 3'd7
  } ev_e;
endpackage

// File: rtl/rcr_event_arb.sv
module rcr_event_arb
  import rcr_pkg::*;
(
  input  logic [EV_N-1:0] req_i,
  output ev_e             sel_o
);
  always_comb begin
    sel_o = EV_NONE;
    for (int i = EV_N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = ev_e'(i);
    end
  end
endmodule

// File: rtl/rcr_flag_upd.sv
module rcr_flag_upd
  import rcr_pkg::*;
(
  input  logic [FLAG_N-1:0] flags_i,
  input  ev_e               sel_i,
  input  logic [1:0]        mode_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic in_idle, in_sleep;
  logic [FLAG_N-1:0] mode_bits;

  assign in_idle   = (mode_i == MODE_IDLE);
  assign in_sleep  = (mode_i == MODE_SLEEP);
  assign mode_bits = (FLAG_N'(in_idle) << F_IDL) | (FLAG_N'(in_sleep) << F_SLP);

  always_comb begin
    flags_o = flags_i;
    unique case (sel_i)
      EV_POR:  flags_o = POR_VAL;
      EV_BOR:  flags_o[F_BOR] = 1'b1;
      EV_EXT:  flags_o = flags_i | mode_bits | (FLAG_N'(1) << F_EXT);
      EV_CM:   flags_o[F_CM] = 1'b1;
      EV_WDT:  flags_o = flags_i | mode_bits | (FLAG_N'(1) << F_WDT);
      EV_SWR:  flags_o[F_SWR] = 1'b1;
      EV_IRQ:  flags_o = flags_i | mode_bits;
      default: flags_o = flags_i;
    endcase
  end
endmodule

// File: rtl/rcr_pc_sel.sv
module rcr_pc_sel
  import rcr_pkg::*;
#(
  parameter int unsigned      PC_W      = 24,
  parameter int unsigned      PRIO_W    = 3,
  parameter logic [PC_W-1:0]  RESET_VEC = '0
) (
  input  ev_e               sel_i,
  input  logic [1:0]        mode_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0] cpu_prio_i,
  input  logic [PC_W-1:0]   cur_pc_i,
  input  logic [PC_W-1:0]   vec_addr_i,
  output logic              load_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic            low_power;
  logic [PC_W-1:0] next_pc;

  assign low_power = (mode_i == MODE_IDLE) || (mode_i == MODE_SLEEP);
  assign next_pc   = cur_pc_i + STEP;
  assign load_o    = (sel_i != EV_NONE);

  always_comb begin
    pc_o = RESET_VEC;
    if (sel_i == EV_WDT && low_power) pc_o = next_pc;
    else if (sel_i == EV_IRQ)
      pc_o = (irq_prio_i <= cpu_prio_i) ? next_pc : vec_addr_i;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter int unsigned      PC_W      = 24,
  parameter int unsigned      PRIO_W    = 3,
  parameter logic [PC_W-1:0]  RESET_VEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              ext_i,
  input  logic              swr_i,
  input  logic              cm_i,
  input  logic              wdt_i,
  input  logic              irq_wake_i,
  input  logic [1:0]        mode_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0] cpu_prio_i,
  input  logic [PC_W-1:0]   cur_pc_i,
  input  logic [PC_W-1:0]   vec_addr_i,
  input  logic              wr_en_i,
  input  logic [FLAG_N-1:0] wr_data_i,
  input  logic [FLAG_N-1:0] wr_mask_i,
  output logic [FLAG_N-1:0] flags_o,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_o
);
  logic              low_power;
  logic [EV_N-1:0]   req;
  ev_e               sel;
  logic [FLAG_N-1:0] flags_q, flags_ev;
  logic              load_d;
  logic [PC_W-1:0]   pc_d, pc_q;
  logic              load_q;

  assign low_power = (mode_i == MODE_IDLE) || (mode_i == MODE_SLEEP);

  // index = priority rank
  always_comb begin
    req          = '0;
    req[EV_POR]  = por_i;
    req[EV_BOR]  = bor_i;
    req[EV_EXT]  = ext_i;
    req[EV_CM]   = cm_i;
    req[EV_WDT]  = wdt_i;
    req[EV_SWR]  = swr_i;
    req[EV_IRQ]  = irq_wake_i && low_power;
  end

  rcr_event_arb u_arb (.req_i(req), .sel_o(sel));

  rcr_flag_upd u_upd (
    .flags_i(flags_q), .sel_i(sel), .mode_i(mode_i), .flags_o(flags_ev)
  );

  rcr_pc_sel #(.PC_W(PC_W), .PRIO_W(PRIO_W), .RESET_VEC(RESET_VEC)) u_pc (
    .sel_i(sel), .mode_i(mode_i), .irq_prio_i(irq_prio_i), .cpu_prio_i(cpu_prio_i),
    .cur_pc_i(cur_pc_i), .vec_addr_i(vec_addr_i), .load_o(load_d), .pc_o(pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= POR_VAL;
      load_q  <= 1'b0;
      pc_q    <= RESET_VEC;
    end else begin
      load_q <= load_d;
      if (load_d) begin
        flags_q <= flags_ev;
        pc_q    <= pc_d;
      end else if (wr_en_i) begin
        flags_q <= flags_q & ~(wr_mask_i & ~wr_data_i);
      end
    end
  end

  assign flags_o   = flags_q;
  assign pc_load_o = load_q;
  assign pc_o      = pc_q;

  // R1
  por_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (flags_o == POR_VAL) && pc_load_o && (pc_o == RESET_VEC));

  // R2
  bor_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_i && !por_i) |=> flags_o == ($past(flags_o) | FLAG_N'(1 << F_BOR)));

  // R7
  run_irq_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_wake_i && !low_power && !por_i && !bor_i && !ext_i && !cm_i && !wdt_i
     && !swr_i && !wr_en_i) |=> !pc_load_o && $stable(flags_o));

  // R8
  irq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_wake_i && low_power && !por_i && !bor_i && !ext_i && !cm_i && !wdt_i && !swr_i)
    |=> pc_o == (($past(irq_prio_i) <= $past(cpu_prio_i)) ?
                 PC_W'($past(cur_pc_i) + PC_W'(2)) : $past(vec_addr_i)));

  // R10
  w0c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !por_i && !bor_i && !ext_i && !cm_i && !wdt_i && !swr_i
     && !(irq_wake_i && low_power))
    |=> flags_o == ($past(flags_o) & ~($past(wr_mask_i) & ~$past(wr_data_i))));

  // R12
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_load_o |-> $stable(pc_o));
endmodule

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        por_i = 0, bor_i = 0, ext_i = 0, swr_i = 0, cm_i = 0, wdt_i = 0, irq_wake_i = 0;
  logic [1:0]  mode_i = 2'b00;
  logic [2:0]  irq_prio_i = 0, cpu_prio_i = 0;
  logic [23:0] cur_pc_i = 0, vec_addr_i = 0;
  logic        wr_en_i = 0;
  logic [7:0]  wr_data_i = 0, wr_mask_i = 0;
  logic [7:0]  flags_o;
  logic        pc_load_o;
  logic [23:0] pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  flags;
    logic        load;
    logic [23:0] pc;
    string       req;
  } exp_t;
  exp_t sb[$];

  rst_cause_reg dut (.*);

  always #5 clk_i = ~clk_i;

  // monitor: compare one item per cycle after the edge
  always @(posedge clk_i) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      #2;
      checks++;
      if (flags_o !== e.flags || pc_load_o !== e.load || (e.load && pc_o !== e.pc)) begin
        errors++;
        $display("FAIL %s: flags=%h load=%b pc=%h expected flags=%h load=%b pc=%h",
                 e.req, flags_o, pc_load_o, pc_o, e.flags, e.load, e.pc);
      end
    end
  end

  // ev bits: {irq,wdt,cm,swr,ext,bor,por}
  task automatic step(input logic [6:0] ev, input logic [1:0] md,
                      input logic [23:0] cpc, input logic [2:0] ip, input logic [2:0] cp,
                      input logic [23:0] va, input logic we, input logic [7:0] wd,
                      input logic [7:0] wm, input logic [7:0] ef, input logic el,
                      input logic [23:0] epc, input string rq);
    exp_t e;
    @(negedge clk_i);
    {irq_wake_i, wdt_i, cm_i, swr_i, ext_i, bor_i, por_i} = ev;
    mode_i = md; cur_pc_i = cpc; irq_prio_i = ip; cpu_prio_i = cp; vec_addr_i = va;
    wr_en_i = we; wr_data_i = wd; wr_mask_i = wm;
    e.flags = ef; e.load = el; e.pc = epc; e.req = rq;
    sb.push_back(e);
  endtask

  task automatic clr(input logic [7:0] ef);
    step(7'h00, 2'b00, 0, 0, 0, 0, 1'b1, 8'h00, 8'hFF, ef, 1'b0, 0, "R10 clear all");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #23;
    checks++;
    if (flags_o !== 8'h03 || pc_load_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: flags=%h load=%b expected flags=03 load=0", flags_o, pc_load_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    clr(8'h00);
    step(7'h02, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'h02, 1, 24'h0, "R2 brown-out");
    step(7'h04, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'h06, 1, 24'h0, "R3 ext run");
    step(7'h04, 2'b01, 0, 0, 0, 0, 0, 0, 0, 8'h46, 1, 24'h0, "R3 ext idle");
    step(7'h04, 2'b10, 0, 0, 0, 0, 0, 0, 0, 8'h66, 1, 24'h0, "R3 ext sleep");
    step(7'h08, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'h6E, 1, 24'h0, "R4 sw reset");
    step(7'h10, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'hEE, 1, 24'h0, "R5 cfg mismatch");
    step(7'h00, 2'b00, 0, 0, 0, 0, 1, 8'h0A, 8'h0F, 8'hEA, 0, 0, "R10 masked clear");
    step(7'h00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'hEA, 0, 0, "R12 idle cycle");
    clr(8'h00);
    step(7'h20, 2'b00, 24'h000500, 0, 0, 0, 0, 0, 0, 8'h10, 1, 24'h0, "R6 wdt run");
    step(7'h20, 2'b01, 24'h001000, 0, 0, 0, 0, 0, 0, 8'h50, 1, 24'h001002, "R6 wdt idle");
    step(7'h20, 2'b10, 24'hFFFFFF, 0, 0, 0, 0, 0, 0, 8'h70, 1, 24'h000001, "R6 wdt sleep wrap");
    clr(8'h00);
    step(7'h40, 2'b00, 24'h000100, 7, 0, 24'h000800, 0, 0, 0, 8'h00, 0, 0, "R7 irq in run");
    step(7'h40, 2'b11, 24'h000100, 7, 0, 24'h000800, 0, 0, 0, 8'h00, 0, 0, "R7 irq mode 11");
    step(7'h40, 2'b01, 24'h123456, 3, 3, 24'h000800, 0, 0, 0, 8'h40, 1, 24'h123458, "R8 irq equal prio");
    step(7'h40, 2'b10, 24'h123456, 5, 2, 24'h000400, 0, 0, 0, 8'h60, 1, 24'h000400, "R8 irq higher prio");
    step(7'h40, 2'b01, 24'h000010, 1, 4, 24'h000400, 0, 0, 0, 8'h60, 1, 24'h000012, "R8 irq lower prio");
    step(7'h40, 2'b01, 24'h000010, 4, 3, 24'h000400, 0, 0, 0, 8'h60, 1, 24'h000400, "R8 irq one above");
    clr(8'h00);
    step(7'h0D, 2'b01, 0, 0, 0, 0, 0, 0, 0, 8'h03, 1, 24'h0, "R9 por beats ext/sw");
    clr(8'h00);
    step(7'h06, 2'b01, 0, 0, 0, 0, 0, 0, 0, 8'h02, 1, 24'h0, "R9 bor beats ext");
    clr(8'h00);
    step(7'h30, 2'b01, 24'h000200, 0, 0, 0, 0, 0, 0, 8'h80, 1, 24'h0, "R9 cm beats wdt");
    clr(8'h00);
    step(7'h28, 2'b01, 24'h000200, 0, 0, 0, 0, 0, 0, 8'h50, 1, 24'h000202, "R9 wdt beats sw");
    clr(8'h00);
    step(7'h48, 2'b01, 24'h000200, 0, 7, 24'h000900, 0, 0, 0, 8'h08, 1, 24'h0, "R9 sw beats irq");
    step(7'h02, 2'b00, 0, 0, 0, 0, 1, 8'h00, 8'hFF, 8'h0A, 1, 24'h0, "R11 event beats clear");
    step(7'h00, 2'b00, 0, 0, 0, 0, 1, 8'hF5, 8'hFF, 8'h00, 0, 0, "R10 clear bits 1,3");
    step(7'h00, 2'b00, 0, 0, 0, 0, 1, 8'h00, 8'h00, 8'h00, 0, 0, "R10 no set");
    step(7'h01, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'h03, 1, 24'h0, "R1 por event");
    step(7'h00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 8'h03, 0, 0, "R12 load drops");
    @(negedge clk_i);
    {irq_wake_i, wdt_i, cm_i, swr_i, ext_i, bor_i, por_i} = '0;
    wr_en_i = 0;
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule